// File: doc/BRIEF.md
# SHA-1 Four-Round Compression Unit

This unit advances a SHA-1 working state by four consecutive rounds. The caller supplies the packed state words A, B, C and D. It also supplies a packed word of four message lanes, in which the first lane already carries the incoming fifth state word added to the first message word. A 2-bit selector picks one boolean function and one round constant, and that pair applies to all four rounds. The unit returns the updated A, B, C and D in the same packing. The final fifth word is dropped.

The block is sequential. It executes one round per clock. A single-cycle `in_valid` pulse starts an operation while the unit is idle. The result appears together with a one-cycle `out_valid` pulse. Message scheduling, padding, forming the first lane and the final addition to the hash are all done by the surrounding logic.

Top module: `sha1r4_core`

## Requirements
- R1: `in_state` packs A in [127:96], B in [95:64], C in [63:32] and D in [31:0]. `out_state` uses the same positions for the updated words.
- R2: An `in_valid` high seen at a rising edge while idle captures `in_state`, `in_msg` and `in_sel`, and starts an operation.
- R3: `out_valid` is high for exactly one cycle. It rises after the fourth rising edge following the capturing edge, and `out_state` holds the result in that cycle.
- R4: Round 0 forms the new A as f(B,C,D) + (A rotated left 5) + lane0 + K. Lane0 is `in_msg[127:96]`, and no separate E term is added.
- R5: Rounds 1, 2 and 3 use lanes `in_msg[95:64]`, `[63:32]` and `[31:0]` in that order, and add E, which is the D of the prior round.
- R6: In every round the new B is the old A, the new C is the old B rotated left 30, the new D is the old C, and the new E is the old D.
- R7: Selector 0 gives (B&C)|(~B&D) with K=5A827999h. Selector 1 gives B^C^D with 6ED9EBA1h. Selector 2 gives the majority (B&C)|(B&D)|(C&D) with 8F1BBCDCh. Selector 3 gives B^C^D with CA62C1D6h. One pair applies to all four rounds.
- R8: All sums wrap modulo 2^32.
- R9: `in_valid` is ignored while an operation is running. The running result is unchanged, and no extra `out_valid` follows.
- R10: A synchronous active-low `rst_n` returns the unit to idle with `out_valid` low. This also aborts a running operation, which then produces no `out_valid`.
- R11: The unit is idle in the cycle in which `out_valid` is high, so an `in_valid` in that cycle starts the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Start request, accepted only when idle |
| in_state | input | 128 | Packed A, B, C, D |
| in_msg | input | 128 | Packed message lanes, lane0 includes E |
| in_sel | input | 2 | Function and constant selector |
| out_valid | output | 1 | One-cycle result strobe |
| out_state | output | 128 | Packed updated A, B, C, D |

## Verification
The result strobe of one operation and the acceptance of the next one can fall in the same cycle. The bench provokes this by raising `in_valid` exactly in the cycle `out_valid` is high, with new data. It judges the first result as read in that cycle. It also judges the second operation's result and latency against the bench's own round model. A second overlap, a start request landing in a busy cycle, is judged by confirming that the running result matches the first operands and that no extra strobe follows.

// File: rtl/sha1r4_pkg.sv
// Package: shared sizes, word type and helpers for the four-round unit.
// Assumes a 32-bit SHA-1 word; the lane count equals the round count.
package sha1r4_pkg;
    parameter int WORD_W  = 32;
    parameter int LANES   = 4;
    localparam int PACK_W = WORD_W * LANES;
    localparam int CNT_W  = $clog2(LANES);

    typedef logic [WORD_W-1:0] word_t;

    // Rotate a word left by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/sha1r4_func.sv
// Selects the boolean function and round constant from a 2-bit selector.
// Purely combinational; assumes the selector is held for a whole operation.
module sha1r4_func
    import sha1r4_pkg::*;
(
    input  logic [1:0] sel,
    input  word_t      b,
    input  word_t      c,
    input  word_t      d,
    output word_t      f,
    output word_t      k
);
    // Decode the selector into one function value and constant.
    always_comb begin
        unique case (sel)
            2'd0: begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            2'd1: begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            2'd2: begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            default: begin f = b ^ c ^ d;                k = 32'hCA62C1D6; end
        endcase
    end
endmodule

// File: rtl/sha1r4_round.sv
// One SHA-1 round: computes the next A..E from the current words, the
// current message lane and the selector. Combinational; E is zero in
// round 0 because the caller folded it into the first lane.
module sha1r4_round
    import sha1r4_pkg::*;
(
    input  logic [1:0] sel,
    input  word_t      a,
    input  word_t      b,
    input  word_t      c,
    input  word_t      d,
    input  word_t      e,
    input  word_t      w,
    output word_t      na,
    output word_t      nb,
    output word_t      nc,
    output word_t      nd,
    output word_t      ne
);
    word_t fv;
    word_t kv;

    sha1r4_func u_func (
        .sel (sel),
        .b   (b),
        .c   (c),
        .d   (d),
        .f   (fv),
        .k   (kv)
    );

    // Sum for the new A and the word shift for the rest.
    always_comb begin
        na = fv + rotl(a, 5) + w + e + kv;
        nb = a;
        nc = rotl(b, 30);
        nd = c;
        ne = d;
    end
endmodule

// File: rtl/sha1r4_ctrl.sv
// Sequencer: accepts a start while idle, counts LANES rounds and raises
// the result strobe for one cycle. Assumes a synchronous active-low reset.
module sha1r4_ctrl
    import sha1r4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic [CNT_W-1:0] rnd,
    output logic             out_valid
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    // Start when idle; advance one round per cycle when busy.
    assign load = in_valid && !busy;
    assign step = busy;

    // Round counter, busy flag and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            rnd       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= busy && (rnd == LAST);
            if (!busy) begin
                if (in_valid) begin
                    busy <= 1'b1;
                    rnd  <= '0;
                end
            end else if (rnd == LAST) begin
                busy <= 1'b0;
                rnd  <= '0;
            end else begin
                rnd <= rnd + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sha1r4_core.sv
// Top: four SHA-1 rounds over a packed state, one round per clock.
// Holds A..E, the message lanes and the selector in registers; the
// output is the live A..D registers, valid while out_valid is high.
module sha1r4_core
    import sha1r4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PACK_W-1:0] in_state,
    input  logic [PACK_W-1:0] in_msg,
    input  logic [1:0]        in_sel,
    output logic              out_valid,
    output logic [PACK_W-1:0] out_state
);
    logic             load;
    logic             step;
    logic             busy_w;
    logic [CNT_W-1:0] rnd_w;

    word_t       a_q, b_q, c_q, d_q, e_q;
    word_t       na, nb, nc, nd, ne;
    logic [1:0]  sel_q;
    logic [PACK_W-1:0] msg_q;
    word_t       lane [LANES];
    word_t       w_cur;

    sha1r4_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .load      (load),
        .step      (step),
        .busy      (busy_w),
        .rnd       (rnd_w),
        .out_valid (out_valid)
    );

    // Unpack the message lanes; lane 0 sits in the top word.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = msg_q[(LANES-1-i)*WORD_W +: WORD_W];
    end

    assign w_cur = lane[rnd_w];

    sha1r4_round u_round (
        .sel (sel_q),
        .a   (a_q),
        .b   (b_q),
        .c   (c_q),
        .d   (d_q),
        .e   (e_q),
        .w   (w_cur),
        .na  (na),
        .nb  (nb),
        .nc  (nc),
        .nd  (nd),
        .ne  (ne)
    );

    // Capture operands on start, apply one round per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {a_q, b_q, c_q, d_q, e_q} <= '0;
            msg_q <= '0;
            sel_q <= '0;
        end else if (load) begin
            {a_q, b_q, c_q, d_q} <= in_state;
            e_q   <= '0;
            msg_q <= in_msg;
            sel_q <= in_sel;
        end else if (step) begin
            a_q <= na;
            b_q <= nb;
            c_q <= nc;
            d_q <= nd;
            e_q <= ne;
        end
    end

    assign out_state = {a_q, b_q, c_q, d_q};
endmodule

// File: rtl/sha1r4_core_chk.sv
// Checker for sha1r4_core: handshake and sequencing properties.
// Bound to the top; observes ports and the sequencer's busy and count.
module sha1r4_core_chk
    import sha1r4_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             busy,
    input logic [CNT_W-1:0] rnd
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_valid && !busy)); // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !busy) |=> (busy && rnd == '0)); // R2
    AST_ROUND_ADV: assert property (@(posedge clk) disable iff (!rst_n) (busy && rnd != LAST) |=> (busy && rnd == CNT_W'($past(rnd) + 1'b1))); // R9
    AST_LAST_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (busy && rnd == LAST) |=> (out_valid && !busy)); // R3
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R3
    AST_IDLE_AT_OUT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !busy); // R11
endmodule

bind sha1r4_core sha1r4_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .busy      (busy_w),
    .rnd       (rnd_w)
);

// File: tb/sha1r4_core_test.sv
`timescale 1ns/1ps
module sha1r4_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_state = '0;
    logic [127:0] in_msg = '0;
    logic [1:0]   in_sel = '0;
    logic         out_valid;
    logic [127:0] out_state;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sha1r4_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_state  (in_state),
        .in_msg    (in_msg),
        .in_sel    (in_sel),
        .out_valid (out_valid),
        .out_state (out_state)
    );

    // Behavioural model of four rounds, written from the requirements.
    function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] m,
                                           input logic [1:0] sel);
        logic [31:0] a, b, c, d, e, f, k, t, w;
        a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0]; e = 0;
        for (int i = 0; i < 4; i++) begin
            w = m[127 - 32*i -: 32];
            case (sel)
                2'd0: begin f = (b & c) | (~b & d); k = 32'h5A827999; end
                2'd1: begin f = b ^ c ^ d; k = 32'h6ED9EBA1; end
                2'd2: begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
                default: begin f = b ^ c ^ d; k = 32'hCA62C1D6; end
            endcase
            t = f + {a[26:0], a[31:27]} + w + e + k;
            e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
        end
        return {a, b, c, d};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive a start pulse at the current negedge and check the result and timing.
    task automatic run_op(input logic [127:0] s, input logic [127:0] m,
                          input logic [1:0] sel, input string req);
        logic [127:0] exp;
        exp = model(s, m, sel);
        in_state = s; in_msg = m; in_sel = sel; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R3", "early strobe c1", {127'b0, out_valid}, 128'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R3", "early strobe", {127'b0, out_valid}, 128'd0);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R3", "strobe on fourth round", {127'b0, out_valid}, 128'd1);
        check(out_state == exp, req, "result", out_state, exp);
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R10", "out_valid in reset", {127'b0, out_valid}, 128'd0);
    endtask

    // R1 R4 R5 R6 R7: one operation per selector value.
    task automatic t_selectors;
        for (int s = 0; s < 4; s++) begin
            run_op(128'h67452301_EFCDAB89_98BADCFE_10325476,
                   128'h11111111_22222222_33333333_44444444 + 128'(s), 2'(s), "R7");
            @(negedge clk);
            check(out_valid == 1'b0, "R3", "strobe one cycle", {127'b0, out_valid}, 128'd0);
        end
        // R4 R5 R6: distinct lanes expose lane order and the E path.
        run_op(128'h01234567_89ABCDEF_FEDCBA98_76543210,
               128'hDEADBEEF_00000001_80000000_0F0F0F0F, 2'd1, "R5");
        @(negedge clk);
        run_op(128'h0, 128'hCAFEF00D_0, 2'd0, "R4");
        @(negedge clk);
        run_op(128'hFFFFFFFF_00000000_FFFFFFFF_00000000, 128'h0, 2'd2, "R6");
        @(negedge clk);
        run_op(128'h80000001_40000002_20000004_10000008, 128'h0, 2'd3, "R1");
        @(negedge clk);
    endtask

    // R8: all-ones operands force every 32-bit sum to wrap.
    task automatic t_wrap;
        for (int s = 0; s < 4; s++) begin
            run_op({128{1'b1}}, {128{1'b1}}, 2'(s), "R8");
            @(negedge clk);
        end
    endtask

    // R9: start requests while busy neither disturb the result nor add a strobe.
    task automatic t_ignore;
        logic [127:0] s0, m0, exp;
        s0 = 128'h13579BDF_2468ACE0_0F1E2D3C_4B5A6978;
        m0 = 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C;
        exp = model(s0, m0, 2'd2);
        in_state = s0; in_msg = m0; in_sel = 2'd2; in_valid = 1'b1;
        @(negedge clk);
        in_state = ~s0; in_msg = ~m0; in_sel = 2'd0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R9", "strobe of first op", {127'b0, out_valid}, 128'd1);
        check(out_state == exp, "R9", "result unaffected", out_state, exp);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", "no extra strobe", {127'b0, out_valid}, 128'd0);
        end
    endtask

    // R11: start the next operation in the cycle the previous result shows.
    task automatic t_back_to_back;
        logic [127:0] s1, m1;
        s1 = 128'hFEDCBA98_76543210_01234567_89ABCDEF;
        m1 = 128'h00000000_FFFFFFFF_12345678_9ABCDEF0;
        run_op(128'h10101010_20202020_30303030_40404040,
               128'h50505050_60606060_70707070_80808080, 2'd3, "R11");
        run_op(s1, m1, 2'd0, "R11");
        @(negedge clk);
    endtask

    // R10: reset mid-operation aborts it; a fresh start then works.
    task automatic t_reset_abort;
        in_state = 128'h1; in_msg = 128'h2; in_sel = 2'd1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            check(out_valid == 1'b0, "R10", "no strobe after abort", {127'b0, out_valid}, 128'd0);
            @(negedge clk);
        end
        run_op(128'h9, 128'h7, 2'd2, "R10");
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_selectors();
        t_wrap();
        t_ignore();
        t_back_to_back();
        t_reset_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule